// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds the program counter of a small processor and moves it on every clock from an already decoded control-flow command. Each cycle the decoder presents a command code, an operand, a register value and a condition selection. The sequencer then advances to the next instruction, takes a relative or absolute jump, jumps through a register, or runs a subroutine linkage. Every command except plain advance and hold can be made conditional on a flag. A conditional command whose flag is false becomes a plain advance.

Two linkage styles are offered. A stacked call saves the address of the following instruction in two bytes onto a 16-entry byte-wide stack kept inside the block. A matching return takes those bytes back off the stack. Each of these takes three cycles, and a busy output tells the front end to hold its command. A link-style jump needs no stack: it puts the return address on a write port for a register file and jumps to a register-supplied target in one cycle. A stack overflow or underflow sets a sticky error flag and leaves the counter where it was.

Top module: `pc_sequencer`

## Requirements
- R1: After reset, pc_o is 0, busy_o, stk_err_o and link_we_o are 0, and the stack is empty, so a return issued first raises stk_err_o.
- R2: Command code 0 (step) sets pc_o to pc_o + 1 at the next edge.
- R3: Command code 1 (relative) adds operand[7:0], sign-extended to 16 bits, to pc_o. operand[15:8] is ignored and the sum wraps modulo 2^16.
- R4: Command code 2 (absolute) loads pc_o with the full 16-bit operand.
- R5: Command code 3 (register jump) loads pc_o with reg_val.
- R6: Command code 4 (call) raises busy_o for the two cycles after the accepting edge, keeping pc_o unchanged. It pushes the byte (pc_o+1)[7:0] and then the byte (pc_o+1)[15:8], and loads pc_o with operand on the third edge.
- R7: Command code 6 (return) raises busy_o for two cycles, pops two bytes, and on the third edge loads pc_o with the address saved by the latest unreturned call.
- R8: Command code 5 (link) loads pc_o with reg_val and, for one cycle, drives link_we_o high with link_data_o equal to the old pc_o + 1. The stack is left untouched.
- R9: With cond_en high and cond_flag low, commands 1 to 6 act as a step: no stack access, no link write, pc_o + 1. With cond_flag high they act normally.
- R10: Commands presented while busy_o is high are ignored.
- R11: A call with fewer than two free stack bytes sets stk_err_o and leaves pc_o unchanged with busy_o low. stk_err_o stays high until reset.
- R12: A return with fewer than two stored bytes sets stk_err_o and leaves pc_o unchanged.
- R13: Command code 7 (hold) leaves pc_o unchanged.
- R14: Eight nested calls fill the stack. Eight returns then restore their return addresses in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 3 | Decoded control-flow command code |
| cond_en | input | 1 | Make the command depend on cond_flag |
| cond_flag | input | 1 | Selected condition flag value |
| operand | input | 16 | Relative offset (low 8 bits) or absolute/call target |
| reg_val | input | 16 | Register value for register jump and link target |
| pc_o | output | 16 | Current program counter |
| busy_o | output | 1 | Multi-cycle call or return in progress |
| stk_err_o | output | 1 | Sticky stack overflow/underflow flag |
| link_we_o | output | 1 | One-cycle link register write strobe |
| link_data_o | output | 16 | Return address for the link register |

## Verification
A corrupted stack pointer or stack byte shows up three cycles after a return is accepted, when pc_o lands on a wrong address. It can also appear at once as a false or missing stk_err_o when a call or return checks the fill level. A wrong sequencer state shows one cycle after the accepting edge as a busy_o window of the wrong length, or as a command taken during the window. The nested fill-then-drain run exposes any error in byte order or pointer direction through the returned addresses alone.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [2:0] {
        CMD_STEP = 3'd0,
        CMD_REL  = 3'd1,
        CMD_ABS  = 3'd2,
        CMD_REG  = 3'd3,
        CMD_CALL = 3'd4,
        CMD_LINK = 3'd5,
        CMD_RET  = 3'd6,
        CMD_HOLD = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_HI = 3'd1,
        ST_CALL_LD = 3'd2,
        ST_POP_LO  = 3'd3,
        ST_RET_LD  = 3'd4
    } seq_e;

endpackage

// File: rtl/pcseq_target.sv
// Computes the candidate next addresses from the current counter.
module pcseq_target #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFS_W-1:0]  offset,
    output logic [ADDR_W-1:0] next_pc,
    output logic [ADDR_W-1:0] rel_pc
);
    localparam int EXT_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] ofs_ext;

    always_comb begin
        ofs_ext = {{EXT_W{offset[OFS_W-1]}}, offset};
        next_pc = pc + ADDR_W'(1);
        rel_pc  = pc + ofs_ext;
    end
endmodule

// File: rtl/pcseq_stack.sv
// Byte-wide return stack; pointer moves down on push, up on pop.
module pcseq_stack #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic [LVL_W-1:0] level
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [LVL_W-1:0] sp_d, sp_q;
    logic [IDX_W-1:0] wr_idx, rd_idx;

    always_comb begin
        wr_idx = IDX_W'(sp_q - LVL_W'(1));
        rd_idx = IDX_W'(sp_q);
        rdata  = mem[rd_idx];
        level  = LVL_W'(DEPTH) - sp_q;
        sp_d   = sp_q;
        if (push) begin
            sp_d = sp_q - LVL_W'(1);
        end else if (pop) begin
            sp_d = sp_q + LVL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= LVL_W'(DEPTH);
        end else begin
            sp_q <= sp_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_idx] <= wdata;
        end
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int OFS_W     = 8,
    parameter int STK_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd,
    input  logic              cond_en,
    input  logic              cond_flag,
    input  logic [ADDR_W-1:0] operand,
    input  logic [ADDR_W-1:0] reg_val,
    output logic [ADDR_W-1:0] pc_o,
    output logic              busy_o,
    output logic              stk_err_o,
    output logic              link_we_o,
    output logic [ADDR_W-1:0] link_data_o
);
    localparam int LVL_W    = $clog2(STK_DEPTH + 1);
    localparam int ADDR_BYT = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        seq_e              state;
        logic [ADDR_W-1:0] tgt;
        logic [7:0]        aux;
        logic              err;
        logic              lwe;
        logic [ADDR_W-1:0] ldata;
    } seq_t;

    seq_t s_d, s_q;

    logic [ADDR_W-1:0] next_pc, rel_pc;
    logic              push, pop;
    logic [7:0]        wdata, rdata;
    logic [LVL_W-1:0]  level;
    logic              take;
    logic              room_ok, fill_ok;

    pcseq_target #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W)
    ) u_target (
        .pc      (s_q.pc),
        .offset  (operand[OFS_W-1:0]),
        .next_pc (next_pc),
        .rel_pc  (rel_pc)
    );

    pcseq_stack #(
        .DEPTH (STK_DEPTH),
        .LVL_W (LVL_W)
    ) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (wdata),
        .rdata (rdata),
        .level (level)
    );

    always_comb begin
        s_d     = s_q;
        s_d.lwe = 1'b0;
        push    = 1'b0;
        pop     = 1'b0;
        wdata   = '0;
        take    = !cond_en || cond_flag;
        room_ok = level <= LVL_W'(STK_DEPTH - ADDR_BYT);
        fill_ok = level >= LVL_W'(ADDR_BYT);

        unique case (s_q.state)
            ST_IDLE: begin
                unique case (cmd_e'(cmd))
                    CMD_STEP: s_d.pc = next_pc;
                    CMD_HOLD: s_d.pc = s_q.pc;
                    CMD_REL:  s_d.pc = take ? rel_pc  : next_pc;
                    CMD_ABS:  s_d.pc = take ? operand : next_pc;
                    CMD_REG:  s_d.pc = take ? reg_val : next_pc;
                    CMD_LINK: begin
                        if (take) begin
                            s_d.pc    = reg_val;
                            s_d.lwe   = 1'b1;
                            s_d.ldata = next_pc;
                        end else begin
                            s_d.pc = next_pc;
                        end
                    end
                    CMD_CALL: begin
                        if (!take) begin
                            s_d.pc = next_pc;
                        end else if (!room_ok) begin
                            s_d.err = 1'b1;
                        end else begin
                            push      = 1'b1;
                            wdata     = next_pc[7:0];
                            s_d.aux   = 8'(next_pc >> 8);
                            s_d.tgt   = operand;
                            s_d.state = ST_PUSH_HI;
                        end
                    end
                    CMD_RET: begin
                        if (!take) begin
                            s_d.pc = next_pc;
                        end else if (!fill_ok) begin
                            s_d.err = 1'b1;
                        end else begin
                            pop       = 1'b1;
                            s_d.aux   = rdata;
                            s_d.state = ST_POP_LO;
                        end
                    end
                    default: s_d.pc = s_q.pc;
                endcase
            end
            ST_PUSH_HI: begin
                push      = 1'b1;
                wdata     = s_q.aux;
                s_d.state = ST_CALL_LD;
            end
            ST_CALL_LD: begin
                s_d.pc    = s_q.tgt;
                s_d.state = ST_IDLE;
            end
            ST_POP_LO: begin
                pop       = 1'b1;
                s_d.tgt   = ADDR_W'({s_q.aux, rdata});
                s_d.state = ST_RET_LD;
            end
            ST_RET_LD: begin
                s_d.pc    = s_q.tgt;
                s_d.state = ST_IDLE;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        pc_o        = s_q.pc;
        busy_o      = s_q.state != ST_IDLE;
        stk_err_o   = s_q.err;
        link_we_o   = s_q.lwe;
        link_data_o = s_q.ldata;
    end
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker
    import pcseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cmd,
    input logic [ADDR_W-1:0] reg_val,
    input logic [ADDR_W-1:0] pc_o,
    input logic              busy_o,
    input logic              stk_err_o,
    input logic              link_we_o,
    input logic [ADDR_W-1:0] link_data_o
);
    // R1: reset forces the idle state
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (pc_o == '0 && !busy_o && !stk_err_o && !link_we_o));

    // R2: step advances by one
    a_r2_step_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && cmd == 3'(CMD_STEP)) |=> pc_o == $past(pc_o) + ADDR_W'(1));

    // R6, R7: busy window is exactly two cycles
    a_r6_busy_second: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |=> busy_o);
    a_r7_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |=> !busy_o);

    // R10: counter frozen while busy
    a_r10_pc_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> $stable(pc_o));

    // R8: link strobe carries old pc + 1 and jumps to reg_val
    a_r8_link_values: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_we_o) |-> (pc_o == $past(reg_val) &&
                              link_data_o == $past(pc_o) + ADDR_W'(1)));

    // R11: error flag is sticky
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err_o |=> stk_err_o);

    // R11, R12: raising the error leaves the counter in place
    a_r12_err_pc_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stk_err_o) |-> $stable(pc_o));
endmodule

bind pc_sequencer pcseq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .reg_val     (reg_val),
    .pc_o        (pc_o),
    .busy_o      (busy_o),
    .stk_err_o   (stk_err_o),
    .link_we_o   (link_we_o),
    .link_data_o (link_data_o)
);

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;
    import pcseq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = 3'(CMD_HOLD);
    logic        cond_en = 1'b0;
    logic        cond_flag = 1'b0;
    logic [15:0] operand = '0;
    logic [15:0] reg_val = '0;
    logic [15:0] pc_o;
    logic        busy_o, stk_err_o, link_we_o;
    logic [15:0] link_data_o;

    always #5 clk = ~clk;

    pc_sequencer u_dut (
        .clk (clk), .rst_n (rst_n), .cmd (cmd), .cond_en (cond_en),
        .cond_flag (cond_flag), .operand (operand), .reg_val (reg_val),
        .pc_o (pc_o), .busy_o (busy_o), .stk_err_o (stk_err_o),
        .link_we_o (link_we_o), .link_data_o (link_data_o)
    );

    typedef struct {
        logic [15:0] pc;
        logic        busy;
        logic        err;
        logic        lwe;
        logic [15:0] ld;
        string       req;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         fails = 0;
    bit         done = 0;
    logic [15:0] m_pc = '0;
    logic [7:0] m_stk[$];
    bit         m_err = 0;

    task automatic push_exp(input bit busy, input bit lwe, input logic [15:0] ld,
                            input string req);
        exp_t e;
        e.pc = m_pc; e.busy = busy; e.err = m_err; e.lwe = lwe; e.ld = ld; e.req = req;
        sb.push_back(e);
    endtask

    task automatic junk();
        cmd = 3'(CMD_ABS); cond_en = 1'b0; operand = 16'hDEAD; reg_val = 16'hBEEF;
    endtask

    task automatic issue(input logic [2:0] c, input bit ce, input bit cf,
                         input logic [15:0] opnd, input logic [15:0] rv,
                         input string req);
        logic [15:0] nxt;
        logic [7:0]  hi, lo;
        bit          take;
        @(negedge clk);
        cmd = c; cond_en = ce; cond_flag = cf; operand = opnd; reg_val = rv;
        nxt  = m_pc + 16'd1;
        take = !ce || cf;
        case (c)
            3'(CMD_STEP): begin m_pc = nxt; push_exp(0, 0, '0, req); end
            3'(CMD_HOLD): push_exp(0, 0, '0, req);
            3'(CMD_REL): begin
                m_pc = take ? m_pc + {{8{opnd[7]}}, opnd[7:0]} : nxt;
                push_exp(0, 0, '0, req);
            end
            3'(CMD_ABS): begin m_pc = take ? opnd : nxt; push_exp(0, 0, '0, req); end
            3'(CMD_REG): begin m_pc = take ? rv : nxt; push_exp(0, 0, '0, req); end
            3'(CMD_LINK): begin
                if (take) begin m_pc = rv; push_exp(0, 1, nxt, req); end
                else begin m_pc = nxt; push_exp(0, 0, '0, req); end
            end
            3'(CMD_CALL): begin
                if (!take) begin
                    m_pc = nxt; push_exp(0, 0, '0, req);
                end else if (m_stk.size() > 14) begin
                    m_err = 1; push_exp(0, 0, '0, req);
                end else begin
                    m_stk.push_back(nxt[7:0]);
                    m_stk.push_back(nxt[15:8]);
                    push_exp(1, 0, '0, req);
                    @(negedge clk); junk(); push_exp(1, 0, '0, {req, "/R10"});
                    @(negedge clk); junk(); m_pc = opnd; push_exp(0, 0, '0, req);
                end
            end
            default: begin
                if (!take) begin
                    m_pc = nxt; push_exp(0, 0, '0, req);
                end else if (m_stk.size() < 2) begin
                    m_err = 1; push_exp(0, 0, '0, req);
                end else begin
                    hi = m_stk.pop_back();
                    lo = m_stk.pop_back();
                    push_exp(1, 0, '0, req);
                    @(negedge clk); junk(); push_exp(1, 0, '0, {req, "/R10"});
                    @(negedge clk); junk(); m_pc = {hi, lo}; push_exp(0, 0, '0, req);
                end
            end
        endcase
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd = 3'(CMD_HOLD); cond_en = 1'b0;
        sb.delete(); m_stk.delete(); m_pc = '0; m_err = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen at the ports
        chk(pc_o == 16'h0, "R1 pc", 32'(pc_o), 32'h0);
        chk({busy_o, stk_err_o, link_we_o} == 3'b000, "R1 flags",
            32'({busy_o, stk_err_o, link_we_o}), 32'h0);
    endtask

    always @(posedge clk) begin
        exp_t e;
        #1;
        if (rst_n && sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (pc_o !== e.pc || busy_o !== e.busy || stk_err_o !== e.err ||
                link_we_o !== e.lwe || (e.lwe && link_data_o !== e.ld)) begin
                fails++;
                $display("FAIL %s: pc=%h busy=%b err=%b lwe=%b ld=%h expected pc=%h busy=%b err=%b lwe=%b ld=%h",
                         e.req, pc_o, busy_o, stk_err_o, link_we_o, link_data_o,
                         e.pc, e.busy, e.err, e.lwe, e.ld);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        issue(3'(CMD_STEP), 0, 0, '0, '0, "R2");
        issue(3'(CMD_STEP), 0, 0, '0, '0, "R2");
        issue(3'(CMD_REL), 0, 0, 16'hFF05, '0, "R3 forward, high byte ignored");
        issue(3'(CMD_REL), 0, 0, 16'h00F0, '0, "R3 backward wrap");
        issue(3'(CMD_ABS), 0, 0, 16'h1234, '0, "R4");
        issue(3'(CMD_REG), 0, 0, 16'h0000, 16'h4000, "R5");
        issue(3'(CMD_HOLD), 0, 0, 16'h5555, 16'h6666, "R13");
        issue(3'(CMD_REL), 1, 0, 16'h0040, '0, "R9 branch not taken");
        issue(3'(CMD_ABS), 1, 1, 16'h0800, '0, "R9 jump taken");
        issue(3'(CMD_CALL), 1, 0, 16'h9000, '0, "R9 call not taken");
        issue(3'(CMD_LINK), 1, 0, '0, 16'h7777, "R9 link not taken");
        issue(3'(CMD_RET), 1, 0, '0, '0, "R9 return not taken");
        issue(3'(CMD_LINK), 0, 0, '0, 16'h2222, "R8");
        issue(3'(CMD_CALL), 0, 0, 16'h3000, '0, "R6");
        issue(3'(CMD_STEP), 0, 0, '0, '0, "R2 inside routine");
        issue(3'(CMD_RET), 1, 1, '0, '0, "R7");
        for (int i = 1; i <= 8; i++) begin
            issue(3'(CMD_CALL), 0, 0, 16'(i * 16'h0100 + 16'h0010), '0, "R14 fill");
        end
        issue(3'(CMD_CALL), 0, 0, 16'hAAAA, '0, "R11 overflow");
        issue(3'(CMD_STEP), 0, 0, '0, '0, "R11 sticky");
        for (int i = 1; i <= 8; i++) begin
            issue(3'(CMD_RET), 0, 0, '0, '0, "R14 drain");
        end
        do_reset();
        issue(3'(CMD_RET), 0, 0, '0, '0, "R12 underflow");
        issue(3'(CMD_STEP), 0, 0, '0, '0, "R12 sticky");
        do_reset();
        issue(3'(CMD_HOLD), 0, 0, '0, '0, "R1 error cleared");
        @(negedge clk);
        cmd = 3'(CMD_HOLD);
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "scoreboard drained", 32'(sb.size()), 32'h0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule